// File: doc/BRIEF.md
# Power-Down Freeze and Wake Controller

This block sits between a chip's pads and its internal logic and implements a pin-driven low-power mode. When the mode is enabled by a configuration bit and either of two request pins goes high, the controller keeps passing live values for a short capture window. It then latches the pad data, the pad output enables and the pin inputs, and holds them. The core sees a steady, defined input picture, and the pads keep driving the values they had. A pad that was tri-stated at that moment stays tri-stated.

When the request is removed, the frozen picture stays in place for a programmable recovery interval, which models the wake-up time of the supply and the clocks. After that interval, live operation resumes. A request that arrives again during recovery cancels the wake-up and does not disturb the held values.

A registered status flag tells the rest of the chip whether the pads are live. All logic runs on one clock. The freeze is an enable on the capture registers, not clock gating.

Top module: `pd_freeze_ctrl`

## Requirements
- R1: While `pd_feature_en` is 0, `pd_req` has no effect: `pd_active` stays 0 and all outputs follow their live inputs.
- R2: With `pd_feature_en` at 1, a 1 on either bit of `pd_req` at a rising clock edge sets `pd_active` to 1 after that edge.
- R3: After entry, the outputs keep following live values for `CAPTURE_CYC` cycles. The held values are the inputs present in the last cycle of that window.
- R4: While frozen, `pad_out` holds the captured core data whatever `core_out` does.
- R5: While frozen, `pad_oe` holds the captured enables, so a tri-stated pad (enable 0) stays tri-stated and a driving pad keeps driving.
- R6: While frozen, `core_in` holds the captured pin levels, and changes on `pin_in` do not reach the core.
- R7: After the request is seen low, the frozen state lasts `RECOVER_CYC` more cycles. Then the outputs are live again and `pd_active` returns to 0.
- R8: A request seen during recovery returns the block to the frozen state with its held values unchanged. A later release restarts the full recovery interval.
- R9: `rst_n` is asynchronous and active low. Asserting it at once clears the frozen state, the held values and `pd_active`. Its release takes effect synchronously after two clock edges.
- R10: In normal operation the outputs follow their inputs combinationally in the same cycle: `core_in` = `pin_in`, `pad_out` = `core_out`, `pad_oe` = `core_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_feature_en | input | 1 | Configuration bit that enables the power-down mode |
| pd_req | input | N_REQ | Power-down request pins; any bit high requests entry |
| pin_in | input | N_IN | Levels arriving from the input pads |
| core_out | input | N_OUT | Output data from the core |
| core_oe | input | N_OUT | Output enables from the core (1 = drive) |
| core_in | output | N_IN | Pin levels presented to the core, live or held |
| pad_out | output | N_OUT | Data sent to the pads, live or held |
| pad_oe | output | N_OUT | Enables sent to the pads, live or held |
| pd_active | output | 1 | Registered flag, 1 from entry until recovery ends |

## Verification
On every cycle, the assertions check that the held pad data, pad enables and core inputs do not move while the freeze persists. They also check that entry raises the status flag on the next edge, that the freeze begins only at the end of the capture window, that the flag drops only when a recovery count has expired with no request, and that a disabled feature keeps the flag low. Only the bench scenarios can show which values are actually held: the last capture-window cycle, the exact length of the recovery interval, and that a cancelled wake-up keeps the original picture. The same applies to the asynchronous clear during an active freeze.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

  typedef enum logic [1:0] {
    PD_RUN    = 2'd0,
    PD_CAPT   = 2'd1,
    PD_FROZEN = 2'd2,
    PD_WAKE   = 2'd3
  } pd_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pdf_rst_sync.sv
module pdf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];

endmodule

// File: rtl/pdf_seq.sv
module pdf_seq
  import pdf_pkg::*;
#(
  parameter int unsigned CAPTURE_CYC = 3,
  parameter int unsigned RECOVER_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic freeze_o,
  output logic pd_active_o
);

  localparam int unsigned CNT_MAX = max_u(max_u(CAPTURE_CYC, RECOVER_CYC), 2);
  localparam int unsigned CW      = $clog2(CNT_MAX);
  localparam logic [CW-1:0] CAP_LD = CW'(CAPTURE_CYC - 1);
  localparam logic [CW-1:0] REC_LD = CW'(RECOVER_CYC - 1);

  pd_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PD_RUN: begin
        if (req_i) begin
          state_d = PD_CAPT;
          cnt_d   = CAP_LD;
        end
      end
      PD_CAPT: begin
        if (cnt_zero) begin
          if (req_i) begin
            state_d = PD_FROZEN;
          end else begin
            state_d = PD_WAKE;
            cnt_d   = REC_LD;
          end
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      PD_FROZEN: begin
        if (!req_i) begin
          state_d = PD_WAKE;
          cnt_d   = REC_LD;
        end
      end
      PD_WAKE: begin
        if (req_i) begin
          state_d = PD_FROZEN;
        end else if (cnt_zero) begin
          state_d = PD_RUN;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: begin
        state_d = PD_RUN;
        cnt_d   = '0;
      end
    endcase
    act_d = (state_d != PD_RUN);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PD_RUN;
      cnt_q   <= '0;
      act_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      act_q   <= act_d;
    end
  end

  assign freeze_o    = (state_q == PD_FROZEN) || (state_q == PD_WAKE);
  assign pd_active_o = act_q;

  // R2: a request seen in normal operation raises the flag on the next edge
  p_entry_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_RUN) && req_i |=> pd_active_o);

  // R3: the freeze starts only at the end of the capture window
  p_window_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freeze_o) |-> ($past(state_q) == PD_CAPT) && $past(cnt_zero));

  // R7: the flag falls only after an expired recovery count with no request
  p_wake_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_active_o) |-> ($past(state_q) == PD_WAKE) && $past(cnt_zero) && !$past(req_i));

  // R8: a request during recovery goes back to the frozen state
  p_cancel_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_WAKE) && req_i |=> (state_q == PD_FROZEN) && freeze_o);

endmodule

// File: rtl/pdf_hold_bank.sv
module pdf_hold_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze_i,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] view_o
);

  logic [W-1:0] held_q;
  logic         cap_en;

  assign cap_en = ~freeze_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= '0;
    else if (cap_en) held_q <= live_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_lane
    assign view_o[i] = freeze_i ? held_q[i] : live_i[i];
  end

endmodule

// File: rtl/pd_freeze_ctrl.sv
module pd_freeze_ctrl #(
  parameter int unsigned N_REQ       = 2,
  parameter int unsigned N_IN        = 8,
  parameter int unsigned N_OUT       = 8,
  parameter int unsigned CAPTURE_CYC = 3,
  parameter int unsigned RECOVER_CYC = 125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_feature_en,
  input  logic [N_REQ-1:0] pd_req,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_IN-1:0]  core_in,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_oe,
  output logic             pd_active
);

  logic srst_n;
  logic req_now;
  logic freeze;

  // request pins are taken to be synchronous to clk
  assign req_now = pd_feature_en & (|pd_req);

  pdf_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pdf_seq #(
    .CAPTURE_CYC (CAPTURE_CYC),
    .RECOVER_CYC (RECOVER_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (srst_n),
    .req_i       (req_now),
    .freeze_o    (freeze),
    .pd_active_o (pd_active)
  );

  pdf_hold_bank #(.W(N_IN)) u_pins (
    .clk (clk), .rst_n (srst_n), .freeze_i (freeze),
    .live_i (pin_in), .view_o (core_in)
  );

  pdf_hold_bank #(.W(N_OUT)) u_data (
    .clk (clk), .rst_n (srst_n), .freeze_i (freeze),
    .live_i (core_out), .view_o (pad_out)
  );

  pdf_hold_bank #(.W(N_OUT)) u_oe (
    .clk (clk), .rst_n (srst_n), .freeze_i (freeze),
    .live_i (core_oe), .view_o (pad_oe)
  );

  // R1: with the feature off the flag never rises
  p_feature_off_r1: assert property (@(posedge clk) disable iff (!srst_n)
    !pd_feature_en && !pd_active |=> !pd_active);

  // R4: pad data is steady across consecutive frozen cycles
  p_hold_data_r4: assert property (@(posedge clk) disable iff (!srst_n)
    freeze && $past(freeze) |-> $stable(pad_out));

  // R5: pad enables are steady across consecutive frozen cycles
  p_hold_oe_r5: assert property (@(posedge clk) disable iff (!srst_n)
    freeze && $past(freeze) |-> $stable(pad_oe));

  // R6: core inputs are steady across consecutive frozen cycles
  p_hold_pins_r6: assert property (@(posedge clk) disable iff (!srst_n)
    freeze && $past(freeze) |-> $stable(core_in));

  // R2: a frozen block always reports itself as powered down
  p_flag_cover_r2: assert property (@(posedge clk) disable iff (!srst_n)
    freeze |-> pd_active);

endmodule

// File: tb/pd_freeze_ctrl_test.sv
module pd_freeze_ctrl_test;

  localparam int unsigned NI = 8;
  localparam int unsigned NO = 8;
  localparam int unsigned NV = 18;
  localparam int unsigned VW = 2 + 1 + 8*6 + 1;

  logic          clk;
  logic          rst_n;
  logic          en;
  logic [1:0]    req;
  logic [NI-1:0] pin_in;
  logic [NO-1:0] core_out;
  logic [NO-1:0] core_oe;
  logic [NI-1:0] core_in;
  logic [NO-1:0] pad_out;
  logic [NO-1:0] pad_oe;
  logic          act;

  int n_cmp = 0;
  int n_bad = 0;

  pd_freeze_ctrl #(
    .N_REQ(2), .N_IN(NI), .N_OUT(NO), .CAPTURE_CYC(3), .RECOVER_CYC(6)
  ) uut (
    .clk (clk), .rst_n (rst_n), .pd_feature_en (en), .pd_req (req),
    .pin_in (pin_in), .core_out (core_out), .core_oe (core_oe),
    .core_in (core_in), .pad_out (pad_out), .pad_oe (pad_oe),
    .pd_active (act)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {req, en, pin_in, core_out, core_oe, exp core_in, exp pad_out, exp pad_oe, exp flag}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'b00, 1'b1, 8'h11, 8'h21, 8'hFF, 8'h11, 8'h21, 8'hFF, 1'b0},
    {2'b01, 1'b1, 8'h12, 8'h22, 8'h0F, 8'h12, 8'h22, 8'h0F, 1'b0},
    {2'b01, 1'b1, 8'h13, 8'h23, 8'h0F, 8'h13, 8'h23, 8'h0F, 1'b1},
    {2'b01, 1'b1, 8'h14, 8'h24, 8'h0F, 8'h14, 8'h24, 8'h0F, 1'b1},
    {2'b01, 1'b1, 8'h15, 8'h25, 8'h0F, 8'h15, 8'h25, 8'h0F, 1'b1},
    {2'b10, 1'b1, 8'hAA, 8'hBB, 8'hFF, 8'h15, 8'h25, 8'h0F, 1'b1},
    {2'b11, 1'b1, 8'hCC, 8'hDD, 8'h00, 8'h15, 8'h25, 8'h0F, 1'b1},
    {2'b00, 1'b1, 8'hEE, 8'hEE, 8'hF0, 8'h15, 8'h25, 8'h0F, 1'b1},
    {2'b00, 1'b1, 8'h80, 8'h90, 8'hA0, 8'h15, 8'h25, 8'h0F, 1'b1},
    {2'b00, 1'b1, 8'h81, 8'h91, 8'hA1, 8'h15, 8'h25, 8'h0F, 1'b1},
    {2'b00, 1'b1, 8'h82, 8'h92, 8'hA2, 8'h15, 8'h25, 8'h0F, 1'b1},
    {2'b00, 1'b1, 8'h83, 8'h93, 8'hA3, 8'h15, 8'h25, 8'h0F, 1'b1},
    {2'b00, 1'b1, 8'h84, 8'h94, 8'hA4, 8'h15, 8'h25, 8'h0F, 1'b1},
    {2'b00, 1'b1, 8'h85, 8'h95, 8'hA5, 8'h15, 8'h25, 8'h0F, 1'b1},
    {2'b00, 1'b1, 8'h86, 8'h96, 8'hA6, 8'h86, 8'h96, 8'hA6, 1'b0},
    {2'b11, 1'b0, 8'h31, 8'h32, 8'h33, 8'h31, 8'h32, 8'h33, 1'b0},
    {2'b11, 1'b0, 8'h34, 8'h35, 8'h36, 8'h34, 8'h35, 8'h36, 1'b0},
    {2'b01, 1'b0, 8'h37, 8'h38, 8'h39, 8'h37, 8'h38, 8'h39, 1'b0}
  };

  task automatic chk(input string tag, input string what,
                     input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic drive(input logic [1:0] r, input logic e, input logic [7:0] pi,
                       input logic [7:0] co, input logic [7:0] oe);
    @(negedge clk);
    req = r; en = e; pin_in = pi; core_out = co; core_oe = oe;
    #2;
  endtask

  task automatic expect_all(input string tag, input logic [7:0] ei, input logic [7:0] eo,
                            input logic [7:0] eoe, input logic ea);
    chk(tag, "core_in", core_in, ei);
    chk(tag, "pad_out", pad_out, eo);
    chk(tag, "pad_oe", pad_oe, eoe);
    chk(tag, "pd_active", {7'd0, act}, {7'd0, ea});
  endtask

  function automatic string row_tag(input int i);
    if (i == 0 || i == 14) return "R10";
    if (i >= 1 && i <= 4)  return "R3";
    if (i >= 5 && i <= 7)  return "R6";
    if (i >= 8 && i <= 13) return "R7";
    return "R1";
  endfunction

  initial begin
    #(8 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; req = 2'b00;
    pin_in = 8'h5A; core_out = 8'h6B; core_oe = 8'h7C;
    repeat (3) @(negedge clk);
    #2;
    // R9: reset state: flag low, live pass-through
    expect_all("R9", 8'h5A, 8'h6B, 8'h7C, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      string t;
      v = VEC[i];
      t = row_tag(i);
      drive(v[51:50], v[49], v[48:41], v[40:33], v[32:25]);
      chk(t, "core_in", core_in, v[24:17]);
      chk((i >= 5 && i <= 13) ? "R4" : t, "pad_out", pad_out, v[16:9]);
      chk((i >= 5 && i <= 13) ? "R5" : t, "pad_oe", pad_oe, v[8:1]);
      chk((i == 2) ? "R2" : t, "pd_active", {7'd0, act}, {7'd0, v[0]});
    end

    // R8: cancelled wake-up keeps the original held picture
    repeat (4) drive(2'b01, 1'b1, 8'h41, 8'h42, 8'h3C);
    drive(2'b01, 1'b1, 8'hB1, 8'hB2, 8'hC3);
    expect_all("R8", 8'h41, 8'h42, 8'h3C, 1'b1);
    drive(2'b00, 1'b1, 8'hB1, 8'hB2, 8'hC3);
    drive(2'b00, 1'b1, 8'hB1, 8'hB2, 8'hC3);
    drive(2'b00, 1'b1, 8'hB1, 8'hB2, 8'hC3);
    drive(2'b01, 1'b1, 8'hB1, 8'hB2, 8'hC3);
    expect_all("R8", 8'h41, 8'h42, 8'h3C, 1'b1);
    drive(2'b00, 1'b1, 8'hB1, 8'hB2, 8'hC3);
    expect_all("R8", 8'h41, 8'h42, 8'h3C, 1'b1);
    for (int k = 0; k < 6; k++) begin
      drive(2'b00, 1'b1, 8'hB1, 8'hB2, 8'hC3);
      expect_all("R8", 8'h41, 8'h42, 8'h3C, 1'b1);
    end
    drive(2'b00, 1'b1, 8'hB1, 8'hB2, 8'hC3);
    expect_all("R7", 8'hB1, 8'hB2, 8'hC3, 1'b0);

    // R9: asynchronous clear during a freeze
    repeat (4) drive(2'b10, 1'b1, 8'h51, 8'h52, 8'h00);
    drive(2'b10, 1'b1, 8'h61, 8'h62, 8'hFF);
    expect_all("R5", 8'h51, 8'h52, 8'h00, 1'b1);
    @(posedge clk); #1;
    rst_n = 1'b0;
    #1;
    expect_all("R9", 8'h61, 8'h62, 8'hFF, 1'b0);
    drive(2'b00, 1'b1, 8'h71, 8'h72, 8'h73);
    rst_n = 1'b1;
    repeat (3) drive(2'b00, 1'b1, 8'h71, 8'h72, 8'h73);
    expect_all("R9", 8'h71, 8'h72, 8'h73, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule